// File: doc/BRIEF.md
# Alpha Block Row Run-Length Bus Link

This block moves one 16x16 binary alpha block across a memory-mapped write bus with as few transfers as the block's content allows. The sending side holds the block as sixteen 16-bit rows and folds each stretch of adjacent equal rows into one tuple. The tuple's row value travels on the 16-bit data bus. The tuple's row count travels in the low bits of the write address, inside a 64-byte window that starts at a programmable base. Every tuple costs exactly one write, so the worst case is sixteen writes, the same as sending the raw rows.

While it encodes, the sender classifies the block. A block whose first tuple spans all sixteen rows, with a value of all zeros, is transparent. The same with all ones is opaque. Anything else is a boundary block. A downstream shape coder can therefore settle its mode for a solid block from a single write.

The receiving side watches the same write bus. It decodes the row count from the address offset within its own window and fills its row store from a running row counter. It presents the rebuilt block once sixteen rows have arrived. It signals an error when a write would push the block past sixteen rows.

Top module: `alpha_rle_link`

## Requirements
- R1: After synchronous reset, `blk_ready` is 1 and `m_wr_en`, `blk_done`, `rec_valid` and `rec_err` are 0.
- R2: Each tuple is issued as a single write with `m_wr_addr` = `win_base` + (count − 1) × 4. Tuples are issued in row order, starting from row 0, one per clock while the block is being sent.
- R3: A tuple's `m_wr_data` is the row value, and its count is the number of adjacent rows equal to it. Equal rows that are not adjacent produce separate tuples.
- R4: A block whose sixteen rows are all 0x0000 is sent as exactly one write at offset 60 with data 0x0000, and `blk_class` is 2'b00 (transparent).
- R5: A block whose sixteen rows are all 0xFFFF is sent as exactly one write at offset 60 with data 0xFFFF, and `blk_class` is 2'b01 (opaque).
- R6: Every other block has `blk_class` 2'b10 (boundary). This includes a block of sixteen equal rows of any other value. A block with no two adjacent rows equal is sent as exactly sixteen writes, each at offset 0.
- R7: `blk_done` is 1 in the same cycle as the block's final write and never otherwise. A block is accepted only when `blk_valid` and `blk_ready` are both 1. `blk_ready` stays 0 while a block is being sent, and `blk_valid` in that time is ignored.
- R8: The receiver acts only on writes whose address lies in [`win_base`, `win_base` + 64) and has bits [1:0] equal to 0. Any other write changes neither its outputs nor its row counter.
- R9: One cycle after the receiving write that brings the row count to exactly 16, `rec_valid` pulses for one cycle and `rec_rows` holds the block, with row r in bits [16r+15:16r].
- R10: If a receiving write would bring the row count above 16, `rec_err` pulses for one cycle instead of `rec_valid`, and the row counter restarts at 0 for the next block.
- R11: `win_base` is programmable. Changing it between blocks moves both the sender's write addresses and the receiver's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_base | input | 32 | Base byte address of the receiver's window |
| blk_valid | input | 1 | A block is offered on `blk_rows` |
| blk_rows | input | 256 | Sixteen 16-bit rows, row r in bits [16r+15:16r] |
| blk_ready | output | 1 | Sender is idle and takes a block |
| m_wr_en | output | 1 | Sender write strobe |
| m_wr_addr | output | 32 | Sender write address carrying the row count |
| m_wr_data | output | 16 | Sender write data, the tuple's row value |
| blk_done | output | 1 | Final write of the block is on the bus |
| blk_class | output | 2 | 00 transparent, 01 opaque, 10 boundary; valid with `blk_done` |
| s_wr_en | input | 1 | Receiver write strobe |
| s_wr_addr | input | 32 | Receiver write address |
| s_wr_data | input | 16 | Receiver write data |
| rec_valid | output | 1 | Rebuilt block is on `rec_rows` |
| rec_rows | output | 256 | Rebuilt block, same row layout as `blk_rows` |
| rec_err | output | 1 | Received row counts overran sixteen rows |

## Verification
On every cycle, the assertions check the following. Each sender write lands in the window and is word aligned. `blk_done` only ever coincides with a write. A solid block, whether transparent or opaque, took exactly one write, and no block took more than sixteen. The receiver never raises `rec_valid` and `rec_err` together, and it reports a block only after a write. Only the bench's scenarios can show that the tuple values, counts and order match the block's actual row pattern. They also show that non-adjacent repeats stay separate, that a stray or misaligned write leaves the receiver's counter untouched, and that the rebuilt rows equal the rows sent.

// File: rtl/alpha_rle_pkg.sv
package alpha_rle_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAR = 2'b00,
    CLS_SOLID = 2'b01,
    CLS_EDGE  = 2'b10
  } blk_class_e;
endpackage

// File: rtl/alpha_run_scan.sv
module alpha_run_scan #(
  parameter int ROW_W = 16,
  parameter int ROWS  = 16,
  localparam int IDX_W = $clog2(ROWS),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic [ROWS*ROW_W-1:0] rows_flat,
  input  logic [IDX_W-1:0]      start,
  output logic [ROW_W-1:0]      run_row,
  output logic [LEN_W-1:0]      run_len
);
  logic [ROW_W-1:0] row_arr [ROWS];

  always_comb begin
    for (int r = 0; r < ROWS; r++) row_arr[r] = rows_flat[r*ROW_W +: ROW_W];
  end

  // Count the stretch of rows equal to the row at start, stopping at the first mismatch.
  always_comb begin
    logic still;
    run_row = row_arr[start];
    run_len = LEN_W'(1);
    still   = 1'b1;
    for (int k = 1; k < ROWS; k++) begin
      if (still && (int'(start) + k < ROWS)) begin
        if (row_arr[int'(start) + k] == run_row) run_len = run_len + LEN_W'(1);
        else still = 1'b0;
      end else begin
        still = 1'b0;
      end
    end
  end
endmodule

// File: rtl/alpha_rle_sender.sv
module alpha_rle_sender
  import alpha_rle_pkg::*;
#(
  parameter int ROW_W       = 16,
  parameter int ROWS        = 16,
  parameter int ADDR_W      = 32,
  parameter int STRIDE_LOG2 = 2,
  localparam int IDX_W = $clog2(ROWS),
  localparam int LEN_W = IDX_W + 1,
  localparam int WIN_BYTES = ROWS << STRIDE_LOG2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     win_base,
  input  logic                  blk_valid,
  input  logic [ROWS*ROW_W-1:0] blk_rows,
  output logic                  blk_ready,
  output logic                  wr_en,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [ROW_W-1:0]      wr_data,
  output logic                  done,
  output blk_class_e            cls
);
  logic                  busy;
  logic [IDX_W-1:0]      ptr;
  logic [ROWS*ROW_W-1:0] row_store;
  logic [ROW_W-1:0]      run_row;
  logic [LEN_W-1:0]      run_len;
  logic                  last_run;
  blk_class_e            cls_n;
  logic [LEN_W-1:0]      xfer_cnt;

  alpha_run_scan #(.ROW_W(ROW_W), .ROWS(ROWS)) u_scan (
    .rows_flat(row_store),
    .start    (ptr),
    .run_row  (run_row),
    .run_len  (run_len)
  );

  assign blk_ready = !busy;
  assign last_run  = (LEN_W'(ptr) + run_len) == LEN_W'(ROWS);

  always_comb begin
    cls_n = CLS_EDGE;
    if (ptr == '0 && run_len == LEN_W'(ROWS)) begin
      if (run_row == '0)      cls_n = CLS_CLEAR;
      else if (run_row == '1) cls_n = CLS_SOLID;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ptr       <= '0;
      row_store <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      done      <= 1'b0;
      cls       <= CLS_CLEAR;
      xfer_cnt  <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (!busy) begin
        if (blk_valid) begin
          row_store <= blk_rows;
          ptr       <= '0;
          busy      <= 1'b1;
          xfer_cnt  <= '0;
        end
      end else begin
        wr_en    <= 1'b1;
        wr_data  <= run_row;
        wr_addr  <= win_base + (ADDR_W'(run_len - LEN_W'(1)) << STRIDE_LOG2);
        ptr      <= ptr + run_len[IDX_W-1:0];
        xfer_cnt <= xfer_cnt + LEN_W'(1);
        if (last_run) begin
          busy <= 1'b0;
          done <= 1'b1;
          cls  <= cls_n;
        end
      end
    end
  end

  AST_SOLID_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (done && cls != CLS_EDGE) |-> xfer_cnt == LEN_W'(1)); // R4
  AST_XFER_LIMIT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> xfer_cnt <= LEN_W'(ROWS)); // R6
  AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    done |-> wr_en); // R7
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $stable(win_base)) |->
      ((wr_addr - win_base) < ADDR_W'(WIN_BYTES) && wr_addr[STRIDE_LOG2-1:0] == win_base[STRIDE_LOG2-1:0])); // R2
endmodule

// File: rtl/alpha_rle_receiver.sv
module alpha_rle_receiver #(
  parameter int ROW_W       = 16,
  parameter int ROWS        = 16,
  parameter int ADDR_W      = 32,
  parameter int STRIDE_LOG2 = 2,
  localparam int IDX_W = $clog2(ROWS),
  localparam int LEN_W = IDX_W + 1,
  localparam int WIN_BYTES = ROWS << STRIDE_LOG2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     win_base,
  input  logic                  s_wr_en,
  input  logic [ADDR_W-1:0]     s_wr_addr,
  input  logic [ROW_W-1:0]      s_wr_data,
  output logic                  rec_valid,
  output logic [ROWS*ROW_W-1:0] rec_rows,
  output logic                  rec_err
);
  logic [ADDR_W-1:0]     offset;
  logic                  hit;
  logic [LEN_W-1:0]      len;
  logic [LEN_W-1:0]      fill;
  logic [LEN_W:0]        total;
  logic [ROW_W-1:0]      row_buf [ROWS];
  logic [ROW_W-1:0]      nxt_buf [ROWS];
  logic [ROWS*ROW_W-1:0] nxt_flat;

  assign offset = s_wr_addr - win_base;
  assign hit    = s_wr_en && (offset < ADDR_W'(WIN_BYTES)) && (offset[STRIDE_LOG2-1:0] == '0);
  assign len    = LEN_W'(offset[STRIDE_LOG2 +: IDX_W]) + LEN_W'(1);
  assign total  = (LEN_W+1)'(fill) + (LEN_W+1)'(len);

  always_comb begin
    for (int k = 0; k < ROWS; k++) begin
      nxt_buf[k] = row_buf[k];
      if (hit && k >= int'(fill) && k < int'(total)) nxt_buf[k] = s_wr_data;
      nxt_flat[k*ROW_W +: ROW_W] = nxt_buf[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      rec_valid <= 1'b0;
      rec_err   <= 1'b0;
      rec_rows  <= '0;
      for (int k = 0; k < ROWS; k++) row_buf[k] <= '0;
    end else begin
      rec_valid <= 1'b0;
      rec_err   <= 1'b0;
      if (hit) begin
        for (int k = 0; k < ROWS; k++) row_buf[k] <= nxt_buf[k];
        if (total == (LEN_W+1)'(ROWS)) begin
          rec_valid <= 1'b1;
          rec_rows  <= nxt_flat;
          fill      <= '0;
        end else if (total > (LEN_W+1)'(ROWS)) begin
          rec_err <= 1'b1;
          fill    <= '0;
        end else begin
          fill <= total[LEN_W-1:0];
        end
      end
    end
  end

  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rec_valid && rec_err)); // R10
  AST_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(s_wr_en)); // R9
  AST_FILL_BELOW_BLOCK: assert property (@(posedge clk) disable iff (rst)
    fill < LEN_W'(ROWS)); // R10
endmodule

// File: rtl/alpha_rle_link.sv
module alpha_rle_link
  import alpha_rle_pkg::*;
#(
  parameter int ROW_W       = 16,
  parameter int ROWS        = 16,
  parameter int ADDR_W      = 32,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     win_base,
  input  logic                  blk_valid,
  input  logic [ROWS*ROW_W-1:0] blk_rows,
  output logic                  blk_ready,
  output logic                  m_wr_en,
  output logic [ADDR_W-1:0]     m_wr_addr,
  output logic [ROW_W-1:0]      m_wr_data,
  output logic                  blk_done,
  output logic [1:0]            blk_class,
  input  logic                  s_wr_en,
  input  logic [ADDR_W-1:0]     s_wr_addr,
  input  logic [ROW_W-1:0]      s_wr_data,
  output logic                  rec_valid,
  output logic [ROWS*ROW_W-1:0] rec_rows,
  output logic                  rec_err
);
  blk_class_e cls_q;

  alpha_rle_sender #(
    .ROW_W(ROW_W), .ROWS(ROWS), .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_sender (
    .clk      (clk),
    .rst      (rst),
    .win_base (win_base),
    .blk_valid(blk_valid),
    .blk_rows (blk_rows),
    .blk_ready(blk_ready),
    .wr_en    (m_wr_en),
    .wr_addr  (m_wr_addr),
    .wr_data  (m_wr_data),
    .done     (blk_done),
    .cls      (cls_q)
  );

  assign blk_class = cls_q;

  alpha_rle_receiver #(
    .ROW_W(ROW_W), .ROWS(ROWS), .ADDR_W(ADDR_W), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_receiver (
    .clk      (clk),
    .rst      (rst),
    .win_base (win_base),
    .s_wr_en  (s_wr_en),
    .s_wr_addr(s_wr_addr),
    .s_wr_data(s_wr_data),
    .rec_valid(rec_valid),
    .rec_rows (rec_rows),
    .rec_err  (rec_err)
  );
endmodule

// File: tb/alpha_rle_link_tb.sv
module alpha_rle_link_tb;
  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] data;
    logic        last;
    logic [1:0]  cls;
  } tup_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  win_base = 32'h0000_2000;
  logic         blk_valid = 1'b0;
  logic [255:0] blk_rows = '0;
  logic         blk_ready, m_wr_en, blk_done, rec_valid, rec_err;
  logic [31:0]  m_wr_addr;
  logic [15:0]  m_wr_data;
  logic [1:0]   blk_class;
  logic [255:0] rec_rows;
  logic         inj_mode = 1'b0, inj_en = 1'b0;
  logic [31:0]  inj_addr = '0;
  logic [15:0]  inj_data = '0;
  logic         s_wr_en;
  logic [31:0]  s_wr_addr;
  logic [15:0]  s_wr_data;
  logic         err_ok = 1'b0;
  logic         finished = 1'b0;
  logic [255:0] bld;
  int checks = 0, errors = 0, cyc = 0;
  tup_t         exp_q[$];
  logic [255:0] blk_q[$];

  assign s_wr_en   = inj_mode ? inj_en   : m_wr_en;
  assign s_wr_addr = inj_mode ? inj_addr : m_wr_addr;
  assign s_wr_data = inj_mode ? inj_data : m_wr_data;

  always #4 clk = ~clk;

  alpha_rle_link u_dut (
    .clk(clk), .rst(rst), .win_base(win_base),
    .blk_valid(blk_valid), .blk_rows(blk_rows), .blk_ready(blk_ready),
    .m_wr_en(m_wr_en), .m_wr_addr(m_wr_addr), .m_wr_data(m_wr_data),
    .blk_done(blk_done), .blk_class(blk_class),
    .s_wr_en(s_wr_en), .s_wr_addr(s_wr_addr), .s_wr_data(s_wr_data),
    .rec_valid(rec_valid), .rec_rows(rec_rows), .rec_err(rec_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Expected tuples from the requirements: adjacent equal rows fold into one write.
  task automatic push_expect(input logic [255:0] rows);
    int p = 0;
    while (p < 16) begin
      int l = 1;
      tup_t t;
      while (p + l < 16 && rows[(p+l)*16 +: 16] == rows[p*16 +: 16]) l++;
      t.addr = win_base + 32'((l - 1) * 4);
      t.data = rows[p*16 +: 16];
      t.last = (p + l == 16);
      t.cls  = 2'b10;
      if (p == 0 && l == 16 && t.data == 16'h0000) t.cls = 2'b00;
      if (p == 0 && l == 16 && t.data == 16'hFFFF) t.cls = 2'b01;
      exp_q.push_back(t);
      p += l;
    end
    blk_q.push_back(rows);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || blk_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_block(input logic [255:0] rows);
    push_expect(rows);
    @(negedge clk);
    while (!blk_ready) @(negedge clk);
    blk_valid = 1'b1;
    blk_rows  = rows;
    @(posedge clk);
    #1 blk_valid = 1'b0;
    drain();
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (m_wr_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected write", {224'd0, m_wr_addr}, '0);
        end else begin
          tup_t t;
          t = exp_q.pop_front();
          chk(m_wr_addr == t.addr, "R2", "write address", {224'd0, m_wr_addr}, {224'd0, t.addr});
          chk(m_wr_data == t.data, "R3", "run row value", {240'd0, m_wr_data}, {240'd0, t.data});
          chk(blk_done == t.last, "R7", "done with final write", {255'd0, blk_done}, {255'd0, t.last});
          if (t.last)
            chk(blk_class == t.cls, (t.cls == 2'b00) ? "R4" : (t.cls == 2'b01) ? "R5" : "R6",
                "block class", {254'd0, blk_class}, {254'd0, t.cls});
        end
      end else if (blk_done) begin
        chk(1'b0, "R7", "done without write", {255'd0, blk_done}, '0);
      end
      if (rec_valid) begin
        if (blk_q.size() == 0) chk(1'b0, "R9", "unexpected rebuilt block", rec_rows, '0);
        else begin
          logic [255:0] e;
          e = blk_q.pop_front();
          chk(rec_rows == e, "R9", "rebuilt rows", rec_rows, e);
        end
      end
      if (rec_err && !err_ok) chk(1'b0, "R10", "unexpected overrun error", {255'd0, rec_err}, '0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic inject(input logic [31:0] a, input logic [15:0] d);
    @(posedge clk);
    #1;
    inj_en   = 1'b1;
    inj_addr = a;
    inj_data = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(blk_ready == 1'b1, "R1", "ready after reset", {255'd0, blk_ready}, 256'd1);
    chk(m_wr_en == 1'b0, "R1", "no write after reset", {255'd0, m_wr_en}, '0);
    chk(blk_done == 1'b0, "R1", "done low after reset", {255'd0, blk_done}, '0);
    chk(rec_valid == 1'b0 && rec_err == 1'b0, "R1", "receiver idle after reset",
        {254'd0, rec_valid, rec_err}, '0);

    // R4 transparent
    send_block('0);
    // R5 opaque
    send_block('1);

    // R3 example: 0x3FFF x2, 0x1FFF x1, 0x003F x4, 0x0000 x9
    bld = '0;
    for (int r = 0; r < 2; r++) bld[r*16 +: 16] = 16'h3FFF;
    bld[2*16 +: 16] = 16'h1FFF;
    for (int r = 3; r < 7; r++) bld[r*16 +: 16] = 16'h003F;
    send_block(bld);

    // R6 every row different: sixteen writes at offset 0
    for (int r = 0; r < 16; r++) bld[r*16 +: 16] = {8'(r + 1), 8'(~r)};
    send_block(bld);

    // R6 sixteen equal rows of a non-solid value: one write, boundary class
    for (int r = 0; r < 16; r++) bld[r*16 +: 16] = 16'h1234;
    send_block(bld);

    // R3 alternating rows: repeats that are not adjacent stay separate
    for (int r = 0; r < 16; r++) bld[r*16 +: 16] = (r % 2 == 0) ? 16'hF0F0 : 16'h0F0F;
    send_block(bld);

    // R7 offer while busy is ignored
    for (int r = 0; r < 16; r++) bld[r*16 +: 16] = 16'(r * 3 + 1);
    push_expect(bld);
    @(negedge clk);
    while (!blk_ready) @(negedge clk);
    blk_valid = 1'b1;
    blk_rows  = bld;
    @(posedge clk);
    #1 blk_rows = 256'hDEAD;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(blk_ready == 1'b0, "R7", "ready low while sending", {255'd0, blk_ready}, '0);
    end
    blk_valid = 1'b0;
    drain();

    // R8 stray and misaligned writes are ignored by the receiver
    inj_mode = 1'b1;
    inject(win_base + 32'd64, 16'hFFFF);
    inject(win_base + 32'd2, 16'hAAAA);
    inject(win_base - 32'd4, 16'h5555);
    @(posedge clk);
    #1 inj_en = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(rec_valid == 1'b0 && rec_err == 1'b0, "R8", "no receiver response to ignored write",
          {254'd0, rec_valid, rec_err}, '0);
    end
    inj_mode = 1'b0;
    // R8 counter untouched: next block decodes from row 0
    for (int r = 0; r < 16; r++) bld[r*16 +: 16] = (r < 5) ? 16'h00FF : 16'hFF00;
    send_block(bld);

    // R9 receiver alone: a count-16 write at offset 60 rebuilds a solid block
    inj_mode = 1'b1;
    blk_q.push_back({16{16'h0FF0}});
    inject(win_base + 32'd60, 16'h0FF0);
    @(posedge clk);
    #1 inj_en = 1'b0;
    @(negedge clk);
    chk(rec_valid == 1'b1, "R9", "valid one cycle after completing write", {255'd0, rec_valid}, 256'd1);
    @(negedge clk);
    chk(rec_valid == 1'b0, "R9", "valid lasts one cycle", {255'd0, rec_valid}, '0);

    // R10 overrun: count 8 then count 16
    err_ok = 1'b1;
    inject(win_base + 32'd28, 16'hAAAA);
    inject(win_base + 32'd60, 16'h5555);
    @(posedge clk);
    #1 inj_en = 1'b0;
    @(negedge clk);
    chk(rec_err == 1'b1, "R10", "overrun error raised", {255'd0, rec_err}, 256'd1);
    chk(rec_valid == 1'b0, "R10", "no block on overrun", {255'd0, rec_valid}, '0);
    @(negedge clk);
    chk(rec_err == 1'b0, "R10", "error lasts one cycle", {255'd0, rec_err}, '0);
    err_ok   = 1'b0;
    inj_mode = 1'b0;
    // R10 counter restarted: next block rebuilds correctly
    for (int r = 0; r < 16; r++) bld[r*16 +: 16] = (r > 11) ? 16'h7777 : 16'h0001;
    send_block(bld);

    // R11 moved window
    win_base = 32'h4000_1000;
    repeat (2) @(negedge clk);
    bld = '0;
    for (int r = 0; r < 2; r++) bld[r*16 +: 16] = 16'h3FFF;
    bld[2*16 +: 16] = 16'h1FFF;
    for (int r = 3; r < 7; r++) bld[r*16 +: 16] = 16'h003F;
    send_block(bld);
    chk(m_wr_addr == 32'h4000_1000 + 32'd32, "R11", "last write in moved window",
        {224'd0, m_wr_addr}, {224'd0, 32'h4000_1020});

    chk(exp_q.size() == 0, "R2", "all expected writes seen", 256'(exp_q.size()), '0);
    chk(blk_q.size() == 0, "R9", "all blocks rebuilt", 256'(blk_q.size()), '0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule